// File: doc/BRIEF.md
# Per-PC Stride Prefetch Engine

This block watches a stream of cache accesses. Each access carries a byte address and the program counter of the instruction that issued it. The block keeps a small, fully associative history table keyed by program counter. Each entry holds the cache line that program counter touched last and the signed line distance it moved the time before that. When an access moves by the same nonzero distance as the stored one, the engine emits a short burst of prefetch line addresses further along that distance.

Requests leave one per cycle over a valid/ready handshake. Every request carries a fill-target flag taken from the live MSHR occupancy: when fewer than half of the MSHRs are in use, the line is to be filled into the local level, and otherwise into the level below. The access port is held off while a burst drains, so the history table and the burst never disagree about which access they belong to.

Top module: `stride_pf_engine`

## Requirements
- R1: A byte address is reduced to its line number by dropping its low 6 bits (64-byte lines). Two addresses that differ only in those bits count as the same line, so the stride between them is zero.
- R2: The first access from a program counter that is not in the table allocates an entry with last line equal to the current line and stored stride zero, and produces no prefetch.
- R3: On a table hit the new stride is current line minus stored line, as a signed value. A burst fires only when the new stride is nonzero and equals the stored stride. Two consecutive equal nonzero moves are therefore needed.
- R4: A burst holds DEGREE requests (default 3), issued in order. Request k, for k from 0, carries line current + stride*(k+1).
- R5: `pf_fill_local` is 1 exactly when 2*`mshr_used` < `mshr_cap`. It is evaluated on the live inputs in the cycle the request is presented.
- R6: Every access that hits overwrites the entry's stored line with the current line and its stored stride with the new stride, whether or not a burst fired. This includes a zero stride.
- R7: The table holds ENTRIES (default 16) program counters and starts with every entry invalid. A miss takes the lowest-numbered invalid entry. When no entry is invalid, a miss evicts the least recently accessed entry, where both hits and allocations count as accesses.
- R8: An access is taken on a cycle where `acc_valid` and `acc_ready` are both high. `acc_ready` is low from the cycle after a firing access until the last request of the burst has been accepted. A request held with `pf_ready` low keeps `pf_valid` high and `pf_line` unchanged.
- R9: A request whose target is negative or above the largest line number (2^26-1) is dropped without being presented. The remaining requests of the burst still follow.
- R10: Negative strides prefetch downward in line order with the same matching rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is offered |
| acc_ready | output | 1 | The engine can take an access (no burst draining) |
| acc_addr | input | 32 | Byte address of the access |
| acc_pc | input | 32 | Program counter of the issuing instruction |
| mshr_used | input | 8 | MSHR entries currently in use |
| mshr_cap | input | 8 | Total MSHR entries |
| pf_valid | output | 1 | A prefetch request is presented |
| pf_ready | input | 1 | The consumer takes the presented request |
| pf_line | output | 26 | Line number to prefetch |
| pf_fill_local | output | 1 | 1: fill the local level, 0: fill the level below |

## Verification
The assertions assume that `mshr_used` never exceeds `mshr_cap` and that the capacity is nonzero. They also assume that `acc_valid` is only treated as accepted in cycles where `acc_ready` is high. The stimulus re-randomizes capacity between 1 and 16 and keeps the in-use count within it every cycle, so the exact half-full boundary is hit often. Accesses are only offered once `acc_ready` has returned. Program counters come from a pool larger than the table, which forces evictions, and some strides are aimed at both ends of the line space.

// File: rtl/pf_pkg.sv
package pf_pkg;

    parameter int ADDR_W   = 32;
    parameter int OFF_W    = 6;
    parameter int PC_W     = 32;
    parameter int LINE_W   = ADDR_W - OFF_W;
    parameter int STRIDE_W = LINE_W + 1;

    typedef logic [ADDR_W-1:0]          addr_t;
    typedef logic [PC_W-1:0]            pc_t;
    typedef logic [LINE_W-1:0]          line_t;
    typedef logic signed [STRIDE_W-1:0] stride_t;

    typedef struct packed {
        logic    valid;
        pc_t     tag;
        line_t   last;
        stride_t stride;
    } hist_entry_t;

    // Drop block-offset bits.
    function automatic line_t to_line(addr_t a);
        return a[ADDR_W-1:OFF_W];
    endfunction

    // Signed distance cur - prev in line units.
    function automatic stride_t line_diff(line_t cur, line_t prev);
        return $signed({1'b0, cur}) - $signed({1'b0, prev});
    endfunction

endpackage

// File: rtl/pf_table.sv
module pf_table
    import pf_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    upd_en,
    input  pc_t     pc,
    input  line_t   cur,
    output logic    hit,
    output stride_t stride_old,
    output stride_t stride_new
);
    localparam int IW = $clog2(ENTRIES);

    hist_entry_t      ent_q [ENTRIES];
    logic [IW-1:0]    age_q [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;
    logic [IW-1:0]    hit_idx, free_idx, lru_idx, sel;
    logic             any_free;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_match
            assign hit_vec[g] = ent_q[g].valid && (ent_q[g].tag == pc);
        end
    endgenerate

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        lru_idx  = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IW'(i);
            if (!ent_q[i].valid) begin
                free_idx = IW'(i);
                any_free = 1'b1;
            end
            if (age_q[i] == IW'(ENTRIES - 1)) lru_idx = IW'(i);
        end
        hit        = |hit_vec;
        sel        = hit ? hit_idx : (any_free ? free_idx : lru_idx);
        stride_old = ent_q[hit_idx].stride;
        stride_new = line_diff(cur, ent_q[hit_idx].last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_q[i] <= '0;
                age_q[i] <= IW'(i);
            end
        end else if (upd_en) begin
            ent_q[sel] <= '{valid: 1'b1, tag: pc, last: cur,
                            stride: (hit ? stride_new : '0)};
            for (int i = 0; i < ENTRIES; i++) begin
                if (IW'(i) == sel)
                    age_q[i] <= '0;
                else if (age_q[i] < age_q[sel])
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    // R7
    one_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

endmodule

// File: rtl/pf_burst.sv
module pf_burst
    import pf_pkg::*;
#(
    parameter int DEGREE = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  line_t   base,
    input  stride_t stride,
    input  logic    pf_ready,
    output logic    busy,
    output logic    pf_valid,
    output line_t   pf_line
);
    localparam int CW = (DEGREE > 1) ? $clog2(DEGREE) : 1;
    localparam int TW = STRIDE_W + $clog2(DEGREE + 1) + 1;

    logic                 busy_q;
    logic [CW-1:0]        cnt_q;
    logic signed [TW-1:0] tgt_q, step_q;
    logic signed [TW-1:0] base_x, step_x;
    logic                 in_range, advance;

    assign base_x   = $signed({{(TW - LINE_W){1'b0}}, base});
    assign step_x   = {{(TW - STRIDE_W){stride[STRIDE_W-1]}}, stride};
    assign in_range = !tgt_q[TW-1] && (tgt_q[TW-2:LINE_W] == '0);
    assign pf_valid = busy_q && in_range;
    assign advance  = busy_q && (!in_range || pf_ready);
    assign pf_line  = tgt_q[LINE_W-1:0];
    assign busy     = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            tgt_q  <= '0;
            step_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            tgt_q  <= base_x + step_x;
            step_q <= step_x;
        end else if (advance) begin
            if (cnt_q == CW'(DEGREE - 1)) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                tgt_q <= tgt_q + step_q;
            end
        end
    end

    // R8
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_line));

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> cnt_q <= CW'(DEGREE - 1));

endmodule

// File: rtl/stride_pf_engine.sv
module stride_pf_engine
    import pf_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int DEGREE  = 3,
    parameter int OCC_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    output logic              acc_ready,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [PC_W-1:0]   acc_pc,
    input  logic [OCC_W-1:0]  mshr_used,
    input  logic [OCC_W-1:0]  mshr_cap,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [LINE_W-1:0] pf_line,
    output logic              pf_fill_local
);
    line_t   cur_line;
    logic    acc_fire, hit, trig, busy;
    stride_t s_old, s_new;
    logic [OCC_W:0] used_x2;

    assign cur_line  = to_line(acc_addr);
    assign acc_ready = !busy;
    assign acc_fire  = acc_valid && acc_ready;
    assign trig      = acc_fire && hit && (s_new != '0) && (s_new == s_old);

    pf_table #(.ENTRIES(ENTRIES)) u_table (
        .clk        (clk),
        .rst        (rst),
        .upd_en     (acc_fire),
        .pc         (acc_pc),
        .cur        (cur_line),
        .hit        (hit),
        .stride_old (s_old),
        .stride_new (s_new)
    );

    pf_burst #(.DEGREE(DEGREE)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .start    (trig),
        .base     (cur_line),
        .stride   (s_new),
        .pf_ready (pf_ready),
        .busy     (busy),
        .pf_valid (pf_valid),
        .pf_line  (pf_line)
    );

    assign used_x2       = {mshr_used, 1'b0};
    assign pf_fill_local = used_x2 < {1'b0, mshr_cap};

    // R8
    gate_acc_chk: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> !acc_ready);

    // R3
    no_trig_chk: assert property (@(posedge clk) disable iff (rst)
        acc_fire && !trig |=> !pf_valid);

endmodule

// File: tb/stride_pf_engine_tb.sv
`timescale 1ns/1ps
module stride_pf_engine_tb;
    import pf_pkg::*;

    localparam int  NENT = 16;
    localparam int  DEG  = 3;
    localparam longint MAXL = (64'sd1 <<< LINE_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_valid = 1'b0, pf_ready = 1'b0;
    logic acc_ready, pf_valid, pf_fill_local;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [PC_W-1:0]   acc_pc = '0;
    logic [7:0] mshr_used = 8'd0, mshr_cap = 8'd8;
    logic [LINE_W-1:0] pf_line;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    stride_pf_engine #(.ENTRIES(NENT), .DEGREE(DEG), .OCC_W(8)) u_dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_ready(acc_ready),
        .acc_addr(acc_addr), .acc_pc(acc_pc), .mshr_used(mshr_used),
        .mshr_cap(mshr_cap), .pf_valid(pf_valid), .pf_ready(pf_ready),
        .pf_line(pf_line), .pf_fill_local(pf_fill_local));

    // reference history model
    bit     m_valid [NENT];
    longint m_tag [NENT], m_last [NENT], m_str [NENT], m_ts [NENT];
    longint now_ts = 0;
    longint exp_q [$];

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NENT; i++) begin
            m_valid[i] = 0; m_ts[i] = 0;
        end
        now_ts = 0;
    endtask

    // Computes expected requests for an access and updates the model.
    task automatic model_access(input longint pc, input longint line);
        int idx = -1;
        exp_q.delete();
        now_ts++;
        for (int i = 0; i < NENT; i++)
            if (m_valid[i] && m_tag[i] == pc) idx = i;
        if (idx >= 0) begin
            longint s = line - m_last[idx];
            if (s != 0 && s == m_str[idx])
                for (int k = 0; k < DEG; k++) begin
                    longint t = line + s * (k + 1);
                    if (t >= 0 && t <= MAXL) exp_q.push_back(t);
                end
            m_str[idx] = s;
        end else begin
            for (int i = NENT - 1; i >= 0; i--)
                if (!m_valid[i]) idx = i;
            if (idx < 0) begin
                idx = 0;
                for (int i = 1; i < NENT; i++)
                    if (m_ts[i] < m_ts[idx]) idx = i;
            end
            m_valid[idx] = 1; m_tag[idx] = pc; m_str[idx] = 0;
        end
        m_last[idx] = line;
        m_ts[idx] = now_ts;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; acc_valid = 1'b0; pf_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        chk("R8 reset acc_ready", acc_ready, 1);
        chk("R7 reset pf_valid", pf_valid, 0);
    endtask

    task automatic do_acc(input string tag, input longint pc, input longint line,
                          input logic [5:0] off);
        int got = 0;
        bit prev_hold = 0;
        longint prev_line = 0;
        model_access(pc, line);
        acc_valid = 1'b1;
        acc_pc    = pc[PC_W-1:0];
        acc_addr  = {line[LINE_W-1:0], off};
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
        #1;
        while (!acc_ready) begin
            bit r;
            int c = $urandom_range(1, 16);
            mshr_cap  = 8'(c);
            mshr_used = 8'($urandom_range(0, c));
            #0.5;
            if (prev_hold) begin
                chk("R8 held request", {pf_valid, 32'(pf_line)}, {1'b1, 32'(prev_line)});
            end
            r = ($urandom_range(0, 3) != 0);
            pf_ready = r;
            if (pf_valid) begin
                chk("R5 fill flag", pf_fill_local,
                    (2 * int'(mshr_used) < int'(mshr_cap)) ? 1 : 0);
                if (r) begin
                    chk({tag, " line"}, pf_line,
                        (got < exp_q.size()) ? exp_q[got] : -1);
                    got++;
                end
            end
            prev_hold = pf_valid && !r;
            prev_line = pf_line;
            @(posedge clk);
            @(negedge clk);
            #1;
        end
        chk({tag, " count"}, got, exp_q.size());
    endtask

    initial begin
        void'($urandom(32'd1234));
        do_reset();

        // R2 first access, then R1 same-line access and R3 matching
        do_acc("R2 first", 32'h100, 64'h40, 6'd0);
        do_acc("R1 same line", 32'h100, 64'h40, 6'd16);
        do_acc("R3 single stride", 32'h100, 64'h41, 6'd5);
        do_acc("R4 burst", 32'h100, 64'h42, 6'd63);
        // R6 zero stride overwrites stored stride
        do_acc("R6 zero move", 32'h100, 64'h42, 6'd1);
        do_acc("R6 after zero", 32'h100, 64'h43, 6'd0);
        do_acc("R3 rematch", 32'h100, 64'h44, 6'd0);
        // R10 negative
        do_acc("R10 a", 32'h200, 100, 6'd0);
        do_acc("R10 b", 32'h200, 97, 6'd0);
        do_acc("R10 down", 32'h200, 94, 6'd0);
        // R9 top and bottom of line space
        do_acc("R9 a", 32'h310, MAXL - 9, 6'd0);
        do_acc("R9 b", 32'h310, MAXL - 6, 6'd0);
        do_acc("R9 top", 32'h310, MAXL - 3, 6'd0);
        do_acc("R9 c", 32'h320, 12, 6'd0);
        do_acc("R9 d", 32'h320, 8, 6'd0);
        do_acc("R9 bottom", 32'h320, 4, 6'd0);
        do_acc("R9 all out a", 32'h330, MAXL - 10, 6'd0);
        do_acc("R9 all out b", 32'h330, MAXL - 5, 6'd0);
        do_acc("R9 all out", 32'h330, MAXL, 6'd0);

        // R7 eviction of the least recently used entry
        do_reset();
        do_acc("R7 p0 a", 32'h1000, 500, 6'd0);
        do_acc("R7 p0 b", 32'h1000, 502, 6'd0);
        for (int i = 1; i <= NENT; i++)
            do_acc("R7 fill", 32'h1000 + i, 1000 + 10 * i, 6'd0);
        do_acc("R7 evicted", 32'h1000, 504, 6'd0);
        do_acc("R7 kept", 32'h1002, 1020 + 3, 6'd0);

        // random mix
        do_reset();
        begin
            longint rl [24], rs [24];
            for (int i = 0; i < 24; i++) begin
                rl[i] = $urandom_range(1000, 60000);
                rs[i] = longint'($urandom_range(0, 8)) - 4;
            end
            for (int n = 0; n < 600; n++) begin
                int p = $urandom_range(0, 23);
                int m = $urandom_range(0, 9);
                if (m == 0) rs[p] = longint'($urandom_range(0, 8)) - 4;
                if (m == 1) rl[p] = $urandom_range(1000, 60000);
                else rl[p] = rl[p] + rs[p];
                do_acc("R4 random", 32'h8000 + p * 4, rl[p], 6'($urandom()));
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule